// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block keeps the tags of a set-associative cache and tells the requester, for each access, whether the addressed block is present. It stores no data. Each request is one address with a valid strobe. One cycle later the block returns a hit flag and the way that either matched or was just filled. It also keeps a running count of accesses and misses. On a miss the directory records the new tag at once, so the next request already sees it.

The request address is split into three fields. The low bits select a byte inside a block and are ignored. The middle bits select the set. All upper bits form the tag. Block size, way count and set count are parameters and must be powers of two, with at least two ways and two sets. A static configuration input picks the replacement policy: least recently used, first-in-first-out or pseudo-random. Whatever the policy, a miss fills an empty way before any victim is chosen.

The control is a two-state machine. ST_IDLE is the state with no response pending. ST_RESP is the state in the cycle after a request. The machine has these transitions:
- IDLE_TO_RESP, taken when a request arrives.
- RESP_TO_RESP, taken on back-to-back requests.
- RESP_TO_IDLE, taken when no request follows.
- IDLE_TO_IDLE, taken while the block stays quiet.

Synchronous reset forces ST_IDLE.

Top module: `cache_tag_dir`

## Requirements
- R1: Address bits [5:0] (log2 of the block size) are ignored. Bits [10:6] pick the set. Bits [31:11] are the tag. Two addresses that differ only in the low bits reach the same entry.
- R2: `rsp_hit` is 1 exactly when a valid way of the indexed set holds the request tag. On a hit, `rsp_way` names that way.
- R3: On a miss, the lowest-numbered invalid way of the set is filled, whatever the policy. The policy is used only when every way in the set is valid.
- R4: With `cfg_policy` = 0 (LRU), each set stamps a way from its own generation counter on every hit or fill, and the counter then increments. The victim is the way with the smallest stamp. On a tie, the lowest-numbered way wins.
- R5: With `cfg_policy` = 1 (FIFO), the victim is the way filled longest ago in that set. Hits do not change this order.
- R6: With `cfg_policy` = 2 (random), a 16-bit shift register supplies the victim. It is seeded with 0xACE1 and shifts left with new bit = b15^b13^b12^b10 once per request. The victim is the low log2(ways) bits of the value held before that request's shift.
- R7: After a miss, the filled way holds the new tag and is valid, so a repeat of the same address hits in that way.
- R8: `acc_cnt` increments by one for every request. `miss_cnt` increments by one for every miss. Neither counter changes in a cycle with no request.
- R9: `rsp_valid`, `rsp_hit` and `rsp_way` are registered and appear one clock after the request cycle. `rsp_valid` is 0 in the cycle after a clock with no request.
- R10: Synchronous reset clears every valid bit, stamp, generation counter, FIFO order, the random generator and both counters. After reset every address misses.
- R11: Filling or evicting in one set never changes the contents of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_policy | input | 2 | Replacement policy: 0 LRU, 1 FIFO, 2 random; held static |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request byte address |
| rsp_valid | output | 1 | A response is presented this cycle |
| rsp_hit | output | 1 | The request hit |
| rsp_way | output | 3 | Way that hit or was filled |
| acc_cnt | output | 32 | Requests since reset |
| miss_cnt | output | 32 | Misses since reset |

## Verification
The bench runs every policy with one fixed script.
- It first makes a compulsory fill of one set. This separates lowest-free-way selection from the policy victim.
- It then touches one way and forces an eviction. LRU must skip the way it touched, while FIFO must still evict the first way it filled.
- Offset-only address changes show that the low bits are ignored.
- Traffic into other sets shows that sets do not interfere.
- Random traffic comes from a small tag pool spread over a few sets. It mixes hits, conflict evictions and idle cycles, and every response is compared with a reference model built from queues and stamps.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
    typedef enum logic [1:0] {
        POL_LRU  = 2'd0,
        POL_FIFO = 2'd1,
        POL_RAND = 2'd2
    } policy_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } dir_state_e;

    localparam logic [15:0] RNG_SEED = 16'hACE1;
endpackage

// File: rtl/tagdir_lookup.sv
// Compares the request tag against every way of one set and finds the
// lowest-numbered empty way.
module tagdir_lookup #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 21,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TAG_W-1:0] set_tags,
    input  logic [WAYS-1:0]            set_vld,
    input  logic [TAG_W-1:0]           req_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic                       has_free,
    output logic [WAY_W-1:0]           free_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = set_vld[w] && (set_tags[w] == req_tag);
    end

    always_comb begin
        hit      = |match;
        has_free = ~&set_vld;
        hit_way  = '0;
        free_way = '0;
        // Scan downward so the lowest index wins.
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w])    hit_way  = WAY_W'(w);
            if (!set_vld[w]) free_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/tagdir_lru_pick.sv
// Returns the way with the smallest stamp; ties go to the lowest index.
module tagdir_lru_pick #(
    parameter int WAYS    = 8,
    parameter int STAMP_W = 32,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][STAMP_W-1:0] stamps,
    output logic [WAY_W-1:0]             min_way
);
    logic [STAMP_W-1:0] best;

    always_comb begin
        best    = stamps[0];
        min_way = '0;
        for (int w = 1; w < WAYS; w++) begin
            if (stamps[w] < best) begin
                best    = stamps[w];
                min_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/tagdir_rng.sv
// 16-bit Fibonacci shift register, one step per request.
module tagdir_rng
    import tagdir_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    output logic [15:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= RNG_SEED;
        end else if (step) begin
            value <= {value[14:0], value[15] ^ value[13] ^ value[12] ^ value[10]};
        end
    end
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
    import tagdir_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64,
    parameter int WAYS      = 8,
    parameter int SETS      = 32,
    parameter int STAMP_W   = 32,
    parameter int CNT_W     = 32,
    localparam int OFF_W = $clog2(BLK_BYTES),
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_policy,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [CNT_W-1:0]  acc_cnt,
    output logic [CNT_W-1:0]  miss_cnt
);
    // Directory storage
    logic [SETS-1:0][WAYS-1:0]              vld_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag_q;
    logic [SETS-1:0][WAYS-1:0][STAMP_W-1:0] stamp_q;
    logic [SETS-1:0][STAMP_W-1:0]           gen_q;
    logic [SETS-1:0][WAY_W-1:0]             fptr_q;

    dir_state_e st_q, st_d;
    policy_e    pol;

    logic [IDX_W-1:0] req_set;
    logic [TAG_W-1:0] req_tag;
    logic             hit, has_free;
    logic [WAY_W-1:0] hit_way, free_way, lru_way, acc_way;
    logic [15:0]      rnd;

    assign pol     = policy_e'(cfg_policy);
    assign req_set = req_addr[OFF_W +: IDX_W];
    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];

    tagdir_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
        .set_tags (tag_q[req_set]),
        .set_vld  (vld_q[req_set]),
        .req_tag  (req_tag),
        .hit      (hit),
        .hit_way  (hit_way),
        .has_free (has_free),
        .free_way (free_way)
    );

    tagdir_lru_pick #(.WAYS(WAYS), .STAMP_W(STAMP_W)) u_lru (
        .stamps  (stamp_q[req_set]),
        .min_way (lru_way)
    );

    tagdir_rng u_rng (
        .clk   (clk),
        .rst   (rst),
        .step  (req_valid),
        .value (rnd)
    );

    // Way selection: hit, then empty way, then policy victim.
    always_comb begin
        if (hit) begin
            acc_way = hit_way;
        end else if (has_free) begin
            acc_way = free_way;
        end else begin
            unique case (pol)
                POL_LRU:  acc_way = lru_way;
                POL_FIFO: acc_way = fptr_q[req_set];
                POL_RAND: acc_way = rnd[WAY_W-1:0];
                default:  acc_way = lru_way;
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: st_d = req_valid ? ST_RESP : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign rsp_valid = (st_q == ST_RESP);

    // Output and statistics registers
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_hit  <= 1'b0;
            rsp_way  <= '0;
            acc_cnt  <= '0;
            miss_cnt <= '0;
        end else if (req_valid) begin
            rsp_hit  <= hit;
            rsp_way  <= acc_way;
            acc_cnt  <= acc_cnt + CNT_W'(1);
            if (!hit) miss_cnt <= miss_cnt + CNT_W'(1);
        end
    end

    // Directory update
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q   <= '0;
            tag_q   <= '0;
            stamp_q <= '0;
            gen_q   <= '0;
            fptr_q  <= '0;
        end else if (req_valid) begin
            if (!hit) begin
                vld_q[req_set][acc_way] <= 1'b1;
                tag_q[req_set][acc_way] <= req_tag;
                // Fills always go in round order, so a rotating pointer
                // reproduces first-in-first-out order.
                fptr_q[req_set]         <= fptr_q[req_set] + WAY_W'(1);
            end
            if (pol == POL_LRU) begin
                stamp_q[req_set][acc_way] <= gen_q[req_set];
                gen_q[req_set]            <= gen_q[req_set] + STAMP_W'(1);
            end
        end
    end
endmodule

// File: rtl/tagdir_chk.sv
module tagdir_chk #(
    parameter int WAY_W = 3,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [WAY_W-1:0] rsp_way,
    input logic [CNT_W-1:0] acc_cnt,
    input logic [CNT_W-1:0] miss_cnt
);
    p_resp_next_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_resp_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_acc_step_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> acc_cnt == $past(acc_cnt) + CNT_W'(1));

    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(acc_cnt) && $stable(miss_cnt));

    p_miss_step_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> miss_cnt == $past(miss_cnt) + (rsp_hit ? CNT_W'(0) : CNT_W'(1)));

    p_miss_bound_r8: assert property (@(posedge clk) disable iff (rst)
        miss_cnt <= acc_cnt);

    p_way_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(rsp_way) && $stable(rsp_hit));
endmodule

bind cache_tag_dir tagdir_chk #(.WAY_W(WAY_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_way   (rsp_way),
    .acc_cnt   (acc_cnt),
    .miss_cnt  (miss_cnt)
);

// File: tb/test_cache_tag_dir.sv
module test_cache_tag_dir;
    localparam int NSETS = 32;
    localparam int NWAYS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_policy = 2'd0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [2:0]  rsp_way;
    logic [31:0] acc_cnt, miss_cnt;

    always #10 clk = ~clk;   // 50 MHz

    cache_tag_dir i_cache_tag_dir (
        .clk(clk), .rst(rst), .cfg_policy(cfg_policy),
        .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .acc_cnt(acc_cnt), .miss_cnt(miss_cnt)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference model
    bit      mv [NSETS][NWAYS];
    int      mt [NSETS][NWAYS];
    longint  ms [NSETS][NWAYS];
    longint  mg [NSETS];
    int      fq [NSETS][$];
    bit [15:0] mlf;
    longint  e_acc, e_miss;
    int      pol;

    function automatic bit [31:0] mk(input int tag, input int set, input int off);
        return (32'(tag) << 11) | (32'(set) << 6) | 32'(off & 63);
    endfunction

    function automatic void model_clear();
        for (int s = 0; s < NSETS; s++) begin
            for (int w = 0; w < NWAYS; w++) begin
                mv[s][w] = 0; mt[s][w] = 0; ms[s][w] = 0;
            end
            mg[s] = 0;
            fq[s].delete();
        end
        mlf = 16'hACE1; e_acc = 0; e_miss = 0;
    endfunction

    function automatic void model(input bit [31:0] a, output bit eh,
                                  output int ew, output bit full);
        int s = int'((a >> 6) & 31);
        int t = int'(a >> 11);
        eh = 0; ew = -1; full = 0;
        for (int w = 0; w < NWAYS; w++)
            if (!eh && mv[s][w] && mt[s][w] == t) begin eh = 1; ew = w; end
        if (!eh) begin
            for (int w = NWAYS - 1; w >= 0; w--) if (!mv[s][w]) ew = w;
            if (ew < 0) begin
                full = 1;
                if (pol == 0) begin
                    ew = 0;
                    for (int w = 1; w < NWAYS; w++) if (ms[s][w] < ms[s][ew]) ew = w;
                end else if (pol == 1) begin
                    ew = fq[s].pop_front();
                end else begin
                    ew = int'(mlf[2:0]);
                end
            end
            mv[s][ew] = 1; mt[s][ew] = t;
            if (pol == 1) fq[s].push_back(ew);
        end
        if (pol == 0) begin ms[s][ew] = mg[s]; mg[s]++; end
        mlf = {mlf[14:0], mlf[15] ^ mlf[13] ^ mlf[12] ^ mlf[10]};
        e_acc++;
        if (!eh) e_miss++;
    endfunction

    task automatic chk(input string rq, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
        end
    endtask

    task automatic access(input bit [31:0] a, output bit eh, output int ew);
        bit full;
        string wl;
        req_valid = 1'b1;
        req_addr  = a;
        model(a, eh, ew, full);
        @(negedge clk);
        req_valid = 1'b0;
        wl = eh ? "R2" : (!full ? "R3" : (pol == 0 ? "R4" : (pol == 1 ? "R5" : "R6")));
        chk("R9 rsp_valid", rsp_valid, 1);
        chk("R2 hit", rsp_hit, eh);
        chk(wl, rsp_way, ew);
        chk("R8 acc", acc_cnt, e_acc);
        chk("R8 miss", miss_cnt, e_miss);
    endtask

    task automatic do_reset();
        rst = 1'b1; req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        chk("R10 rsp_valid", rsp_valid, 0);
        chk("R10 acc", acc_cnt, 0);
        chk("R10 miss", miss_cnt, 0);
    endtask

    initial begin
        bit eh;
        int ew;
        void'($urandom(32'd20240611));
        for (int p = 0; p < 3; p++) begin
            pol = p;
            cfg_policy = 2'(p);
            do_reset();
            // R1: offset bits ignored
            access(mk(5, 3, 0), eh, ew);
            chk("R10 first miss", rsp_hit, 0);
            access(mk(5, 3, 63), eh, ew);
            chk("R1 offset hit", rsp_hit, 1);
            chk("R1 way", rsp_way, 0);
            // R3: compulsory fills go to ways 1..7 in order
            for (int t = 6; t < 13; t++) begin
                access(mk(t, 3, t), eh, ew);
                chk("R3 fill way", rsp_way, t - 5);
            end
            // R7: filled tag now hits
            access(mk(6, 3, 17), eh, ew);
            chk("R7 refill hit", rsp_hit, 1);
            chk("R7 way", rsp_way, 1);
            // R9/R8: idle cycle
            @(negedge clk);
            chk("R9 idle", rsp_valid, 0);
            chk("R8 idle acc", acc_cnt, e_acc);
            // R11: heavy traffic in set 4 leaves set 3 intact
            for (int t = 0; t < 12; t++) access(mk(t, 4, 0), eh, ew);
            for (int t = 5; t < 13; t++) begin
                access(mk(t, 3, 1), eh, ew);
                chk("R11 other set kept", rsp_hit, 1);
            end
            // R4/R5: fill set 7, touch way 0, then evict
            for (int t = 0; t < 8; t++) access(mk(t, 7, 0), eh, ew);
            access(mk(0, 7, 0), eh, ew);
            access(mk(20, 7, 0), eh, ew);
            if (p == 0) chk("R4 lru victim", rsp_way, 1);
            else if (p == 1) chk("R5 fifo victim", rsp_way, 0);
            else chk("R6 rand victim", rsp_way, ew);
            // Random traffic
            for (int i = 0; i < 500; i++) begin
                if ($urandom_range(7) == 0) begin
                    @(negedge clk);
                    chk("R9 idle", rsp_valid, 0);
                end else begin
                    access(mk(int'($urandom_range(11)), int'($urandom_range(2)),
                              int'($urandom_range(63))), eh, ew);
                end
            end
        end
        // R10: reset empties the directory
        do_reset();
        access(mk(5, 3, 0), eh, ew);
        chk("R10 miss after reset", rsp_hit, 0);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule